// File: doc/BRIEF.md
# Read Strobe Delay Centring Sequencer

This block is a hardware sequencer that puts each byte lane's read-strobe delay in the middle of that lane's valid data eye. It takes a starting delay code for every lane and first proves that those codes read the expected pattern correctly. It then sweeps the delay of all lanes downward together to find where each lane stops reading correctly. It sweeps upward from one step above the starting code to find the other edge. Finally it programs each lane to the midpoint of its two edges.

Every probe of the sweep follows the same sequence. Any changed delay codes are first applied through a measure-and-apply request to the delay line. The read FIFO is then reset so that it holds the inverse of the expected pattern. A dummy read is issued next. After a fixed wait, the captured burst is compared byte by byte with the expected pattern. Lanes keep separate boundaries. A lane that has found its edge stops moving, and each direction continues until every lane has found its edge.

Top module: `rd_window_cal`

## Requirements
- R1: A lane passes a probe only when every compared beat byte equals the expected byte for that lane. Byte `b*NUM_LANES + l` of the burst and pattern buses (bits `8*(b*NUM_LANES+l)` upward) is beat `b` of lane `l`. With `burst8_i` = 1, beats 0 to 7 are compared. With `burst8_i` = 0, only beats 0 to 3 are compared and beats 4 to 7 have no effect.
- R2: On `start_i` in idle, every lane's offset is loaded from `init_ofs_i` and `done_o` and `err_o` clear. If any lane fails this first probe, `err_o` rises, `done_o` stays low, the offsets keep their starting values and no further read is issued.
- R3: Each probe issues a one-cycle `fifo_rst_o` pulse and then a one-cycle `dummy_rd_o` pulse. No two of the three request pulses are ever high in the same cycle.
- R4: After any change of `ofs_o`, a `measure_o` pulse occurs before the next `dummy_rd_o`.
- R5: After `dummy_rd_o`, the compare takes place 16 cycles later (`wait_long_i` = 0) or 32 cycles later (`wait_long_i` = 1). The value is latched at start. During the wait no request pulse is issued and `ofs_o` holds steady.
- R6: The downward sweep lowers each still-searching lane's offset by 1 per probe. A lane's lower edge is its lowest offset that passed. Once that edge is found, the lane's offset stays where it is.
- R7: The upward sweep starts every lane at its starting offset plus 1 and raises it by 1 per probe. A lane's upper edge is its highest offset that passed.
- R8: A lane that passes at offset 0 during the downward sweep, or at the maximum code during the upward sweep, takes that limit as its edge. The offset never wraps.
- R9: When both sweeps have ended, each lane's offset becomes floor((lower + upper) / 2). One `measure_o` pulse follows, and then `done_o` rises.
- R10: Each direction ends only when every lane has found its edge. Lanes with different eyes get independent results.
- R11: After reset, `ofs_o` is 0 and every output flag and pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a calibration run when idle |
| burst8_i | input | 1 | 1: compare 8 beats, 0: compare 4 beats |
| wait_long_i | input | 1 | 1: 32-cycle read wait, 0: 16-cycle wait |
| init_ofs_i | input | NUM_LANES*OFS_W | Starting delay code per lane |
| exp_pat_i | input | 64*NUM_LANES | Expected burst pattern |
| rd_burst_i | input | 64*NUM_LANES | Burst data captured by the read FIFO |
| ofs_o | output | NUM_LANES*OFS_W | Per-lane delay offset code |
| measure_o | output | 1 | Delay-line measure-and-apply request pulse |
| fifo_rst_o | output | 1 | Read FIFO reset pulse (fill with inverted pattern) |
| dummy_rd_o | output | 1 | Dummy read request pulse |
| done_o | output | 1 | Calibration completed |
| err_o | output | 1 | Starting codes failed the first check |

## Verification
The bench builds the block with 2 lanes and a 5-bit offset, so codes run from 0 to 31. With these values both saturation limits, and a starting code that sits at the maximum, are reached in a few dozen probes. The two lanes are given different eyes, which shows that they end at different points. A read-latency model of 24 cycles separates the 16-cycle wait from the 32-cycle wait. In 4-beat mode the model corrupts the upper beats, so a compare that wrongly included them would be caught.

// File: rtl/rdcal_pkg.sv
package rdcal_pkg;
    localparam int BYTE_W      = 8;
    localparam int MAX_BEATS   = 8;
    localparam int SHORT_BEATS = 4;
    localparam int LANE_BITS   = MAX_BEATS * BYTE_W;
    localparam int WAIT_SHORT  = 16;
    localparam int WAIT_LONG   = 32;
    localparam int WCNT_W      = $clog2(WAIT_LONG);

    typedef enum logic [2:0] {
        LOP_HOLD,
        LOP_LOAD,
        LOP_DOWN,
        LOP_UP,
        LOP_HIGH,
        LOP_CENTER
    } lane_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MEAS,
        S_FRST,
        S_READ,
        S_WAIT,
        S_CMP,
        S_CHK,
        S_FMEAS
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_INIT,
        PH_LOW,
        PH_HIGH
    } phase_e;

    function automatic logic [WCNT_W-1:0] wait_last(input logic long_sel);
        return long_sel ? WCNT_W'(WAIT_LONG - 1) : WCNT_W'(WAIT_SHORT - 1);
    endfunction
endpackage

// File: rtl/rdcal_lane_cmp.sv
module rdcal_lane_cmp
    import rdcal_pkg::*;
(
    input  logic [LANE_BITS-1:0] got_i,
    input  logic [LANE_BITS-1:0] exp_i,
    input  logic                 bl8_i,
    output logic                 pass_o
);
    always_comb begin
        pass_o = 1'b1;
        for (int b = 0; b < MAX_BEATS; b++) begin
            if ((b < SHORT_BEATS || bl8_i) &&
                (got_i[b*BYTE_W +: BYTE_W] != exp_i[b*BYTE_W +: BYTE_W]))
                pass_o = 1'b0;
        end
    end
endmodule

// File: rtl/rdcal_lane.sv
module rdcal_lane
    import rdcal_pkg::*;
#(
    parameter int OFS_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  lane_op_e         op_i,
    input  logic             pass_i,
    input  logic [OFS_W-1:0] init_i,
    output logic [OFS_W-1:0] ofs_o,
    output logic             active_o
);
    localparam logic [OFS_W-1:0] OFS_MAX = '1;
    localparam logic [OFS_W-1:0] ONE     = OFS_W'(1);

    logic [OFS_W-1:0] ofs_q, lo_q, hi_q;
    logic             act_q;
    logic [OFS_W:0]   sum;

    assign sum      = {1'b0, lo_q} + {1'b0, hi_q};
    assign ofs_o    = ofs_q;
    assign active_o = act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
            act_q <= 1'b0;
        end else begin
            case (op_i)
                LOP_LOAD: begin
                    ofs_q <= init_i;
                    lo_q  <= init_i;
                    hi_q  <= init_i;
                    act_q <= 1'b1;
                end
                LOP_DOWN: if (act_q) begin
                    if (!pass_i) begin
                        lo_q  <= ofs_q + ONE;
                        act_q <= 1'b0;
                    end else if (ofs_q == '0) begin
                        lo_q  <= '0;
                        act_q <= 1'b0;
                    end else begin
                        ofs_q <= ofs_q - ONE;
                    end
                end
                LOP_HIGH: begin
                    if (init_i == OFS_MAX) begin
                        ofs_q <= init_i;
                        hi_q  <= OFS_MAX;
                        act_q <= 1'b0;
                    end else begin
                        ofs_q <= init_i + ONE;
                        act_q <= 1'b1;
                    end
                end
                LOP_UP: if (act_q) begin
                    if (!pass_i) begin
                        hi_q  <= ofs_q - ONE;
                        act_q <= 1'b0;
                    end else if (ofs_q == OFS_MAX) begin
                        hi_q  <= OFS_MAX;
                        act_q <= 1'b0;
                    end else begin
                        ofs_q <= ofs_q + ONE;
                    end
                end
                LOP_CENTER: ofs_q <= sum[OFS_W:1];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rdcal_seq.sv
module rdcal_seq
    import rdcal_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     wait_long_i,
    input  logic     all_pass_i,
    input  logic     any_active_i,
    output lane_op_e op_o,
    output logic     meas_o,
    output logic     frst_o,
    output logic     rd_o,
    output logic     done_o,
    output logic     err_o
);
    seq_state_e        st_q;
    phase_e            ph_q;
    logic [WCNT_W-1:0] wcnt_q;
    logic              wlong_q, done_q, err_q;

    assign meas_o = (st_q == S_MEAS) || (st_q == S_FMEAS);
    assign frst_o = (st_q == S_FRST);
    assign rd_o   = (st_q == S_READ);
    assign done_o = done_q;
    assign err_o  = err_q;

    always_comb begin
        op_o = LOP_HOLD;
        case (st_q)
            S_IDLE: if (start_i) op_o = LOP_LOAD;
            S_CMP: begin
                if (ph_q == PH_HIGH)    op_o = LOP_UP;
                else if (ph_q == PH_LOW) op_o = LOP_DOWN;
                else if (all_pass_i)    op_o = LOP_DOWN;
            end
            S_CHK: if (!any_active_i)
                op_o = (ph_q == PH_HIGH) ? LOP_CENTER : LOP_HIGH;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            ph_q    <= PH_INIT;
            wcnt_q  <= '0;
            wlong_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: if (start_i) begin
                    done_q  <= 1'b0;
                    err_q   <= 1'b0;
                    wlong_q <= wait_long_i;
                    ph_q    <= PH_INIT;
                    st_q    <= S_MEAS;
                end
                S_MEAS: st_q <= S_FRST;
                S_FRST: st_q <= S_READ;
                S_READ: begin
                    wcnt_q <= '0;
                    st_q   <= S_WAIT;
                end
                S_WAIT: begin
                    if (wcnt_q == wait_last(wlong_q)) st_q <= S_CMP;
                    else wcnt_q <= wcnt_q + WCNT_W'(1);
                end
                S_CMP: begin
                    if (ph_q == PH_INIT && !all_pass_i) begin
                        err_q <= 1'b1;
                        st_q  <= S_IDLE;
                    end else begin
                        if (ph_q == PH_INIT) ph_q <= PH_LOW;
                        st_q <= S_CHK;
                    end
                end
                S_CHK: begin
                    if (any_active_i)        st_q <= S_MEAS;
                    else if (ph_q == PH_LOW) ph_q <= PH_HIGH;
                    else                     st_q <= S_FMEAS;
                end
                S_FMEAS: begin
                    done_q <= 1'b1;
                    st_q   <= S_IDLE;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rd_window_cal.sv
module rd_window_cal
    import rdcal_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int OFS_W     = 7
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start_i,
    input  logic                           burst8_i,
    input  logic                           wait_long_i,
    input  logic [NUM_LANES*OFS_W-1:0]     init_ofs_i,
    input  logic [NUM_LANES*LANE_BITS-1:0] exp_pat_i,
    input  logic [NUM_LANES*LANE_BITS-1:0] rd_burst_i,
    output logic [NUM_LANES*OFS_W-1:0]     ofs_o,
    output logic                           measure_o,
    output logic                           fifo_rst_o,
    output logic                           dummy_rd_o,
    output logic                           done_o,
    output logic                           err_o
);
    lane_op_e               op;
    logic [NUM_LANES-1:0]   pass, active;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic [LANE_BITS-1:0] got, expv;
        for (genvar b = 0; b < MAX_BEATS; b++) begin : g_beat
            assign got [b*BYTE_W +: BYTE_W] = rd_burst_i[(b*NUM_LANES+l)*BYTE_W +: BYTE_W];
            assign expv[b*BYTE_W +: BYTE_W] = exp_pat_i [(b*NUM_LANES+l)*BYTE_W +: BYTE_W];
        end

        rdcal_lane_cmp u_cmp (
            .got_i (got),
            .exp_i (expv),
            .bl8_i (burst8_i),
            .pass_o(pass[l])
        );

        rdcal_lane #(.OFS_W(OFS_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .op_i    (op),
            .pass_i  (pass[l]),
            .init_i  (init_ofs_i[l*OFS_W +: OFS_W]),
            .ofs_o   (ofs_o[l*OFS_W +: OFS_W]),
            .active_o(active[l])
        );
    end

    rdcal_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .wait_long_i (wait_long_i),
        .all_pass_i  (&pass),
        .any_active_i(|active),
        .op_o        (op),
        .meas_o      (measure_o),
        .frst_o      (fifo_rst_o),
        .rd_o        (dummy_rd_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );
endmodule

// File: rtl/rd_window_cal_chk.sv
module rd_window_cal_chk #(
    parameter int NUM_LANES = 4,
    parameter int OFS_W     = 7
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_LANES*OFS_W-1:0] ofs_o,
    input logic                       measure_o,
    input logic                       fifo_rst_o,
    input logic                       dummy_rd_o,
    input logic                       done_o,
    input logic                       err_o
);
    localparam int QUIET = 16;

    logic [NUM_LANES*OFS_W-1:0] prev_q;
    logic                       pend_q, armed_q;
    logic [5:0]                 wc_q;
    logic                       changed;

    assign changed = (ofs_o != prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            pend_q  <= 1'b0;
            armed_q <= 1'b0;
            wc_q    <= '0;
        end else begin
            prev_q  <= ofs_o;
            pend_q  <= (changed || pend_q) && !measure_o;
            armed_q <= fifo_rst_o ? 1'b1 : (dummy_rd_o ? 1'b0 : armed_q);
            if (dummy_rd_o)                      wc_q <= 6'd1;
            else if (wc_q != 0 && wc_q < QUIET)  wc_q <= wc_q + 6'd1;
            else                                 wc_q <= '0;
        end
    end

    // R3: request pulses never overlap
    a_r3_one_pulse: assert property (@(posedge clk) disable iff (rst)
        $countones({measure_o, fifo_rst_o, dummy_rd_o}) <= 1);

    // R3: a FIFO reset precedes every dummy read
    a_r3_reset_first: assert property (@(posedge clk) disable iff (rst)
        dummy_rd_o |-> armed_q);

    // R4: no read with an unapplied offset change
    a_r4_measure_first: assert property (@(posedge clk) disable iff (rst)
        dummy_rd_o |-> (!pend_q && !changed));

    // R5: quiet and stable while waiting for read data
    a_r5_quiet_wait: assert property (@(posedge clk) disable iff (rst)
        (wc_q != 0) |-> (!measure_o && !fifo_rst_o && !dummy_rd_o));

    a_r5_ofs_hold: assert property (@(posedge clk) disable iff (rst)
        (wc_q != 0) |-> $stable(ofs_o));

    // R2: error leaves offsets unchanged
    a_r2_err_keeps: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> $stable(ofs_o));

    // R9: done and error are exclusive
    a_r9_flags_excl: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));
endmodule

bind rd_window_cal rd_window_cal_chk #(.NUM_LANES(NUM_LANES), .OFS_W(OFS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ofs_o     (ofs_o),
    .measure_o (measure_o),
    .fifo_rst_o(fifo_rst_o),
    .dummy_rd_o(dummy_rd_o),
    .done_o    (done_o),
    .err_o     (err_o)
);

// File: tb/rd_window_cal_tb.sv
module rd_window_cal_tb;
    localparam int L     = 2;
    localparam int OW    = 5;
    localparam int OMAX  = 31;
    localparam int BW    = L * 64;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start_i = 1'b0, burst8_i = 1'b1, wait_long_i = 1'b0;
    logic [L*OW-1:0] init_ofs_i = '0;
    logic [BW-1:0]  exp_pat_i, rd_burst_i;
    logic [L*OW-1:0] ofs_o;
    logic           measure_o, fifo_rst_o, dummy_rd_o, done_o, err_o;

    int total = 0, bad = 0;
    int wlo[L], whi[L], amin[L], amax[L];
    int applied[L];
    int lat = 12, lat_cnt = 0, reads = 0;
    logic junk_hi = 1'b0;

    always #4 clk = ~clk;

    rd_window_cal #(.NUM_LANES(L), .OFS_W(OW)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .burst8_i(burst8_i),
        .wait_long_i(wait_long_i), .init_ofs_i(init_ofs_i), .exp_pat_i(exp_pat_i),
        .rd_burst_i(rd_burst_i), .ofs_o(ofs_o), .measure_o(measure_o),
        .fifo_rst_o(fifo_rst_o), .dummy_rd_o(dummy_rd_o), .done_o(done_o), .err_o(err_o)
    );

    initial begin
        for (int i = 0; i < L*8; i++) exp_pat_i[i*8 +: 8] = 8'((i * 37 + 11) & 255);
        rd_burst_i = '0;
        for (int l = 0; l < L; l++) applied[l] = 0;
    end

    // delay line + FIFO + memory model
    always @(posedge clk) begin
        if (measure_o) begin
            for (int l = 0; l < L; l++) begin
                applied[l] = int'(ofs_o[l*OW +: OW]);
                if (applied[l] < amin[l]) amin[l] = applied[l];
                if (applied[l] > amax[l]) amax[l] = applied[l];
            end
        end
        if (fifo_rst_o) rd_burst_i <= ~exp_pat_i;
        if (dummy_rd_o) begin
            reads++;
            lat_cnt = lat;
        end else if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                for (int b = 0; b < 8; b++)
                    for (int l = 0; l < L; l++) begin
                        int idx;
                        logic [7:0] e;
                        idx = b * L + l;
                        e = exp_pat_i[idx*8 +: 8];
                        if (b >= 4 && junk_hi) rd_burst_i[idx*8 +: 8] <= e ^ 8'hA5;
                        else if (applied[l] >= wlo[l] && applied[l] <= whi[l])
                            rd_burst_i[idx*8 +: 8] <= e;
                        else rd_burst_i[idx*8 +: 8] <= ~e;
                    end
            end
        end
    end

    task automatic chk(string req, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic run_cal(int i0, int i1, logic bl8, logic wl, int latency);
        @(negedge clk);
        init_ofs_i = {OW'(i1), OW'(i0)};
        burst8_i = bl8; wait_long_i = wl; lat = latency;
        reads = 0;
        for (int l = 0; l < L; l++) begin amin[l] = OMAX + 1; amax[l] = -1; end
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int n = 0; n < 20000 && !(done_o || err_o); n++) @(negedge clk);
    endtask

    function automatic int lane_ofs(int l);
        return int'(ofs_o[l*OW +: OW]);
    endfunction

    task automatic win(int l0a, int l0b, int l1a, int l1b);
        wlo[0] = l0a; whi[0] = l0b; wlo[1] = l1a; whi[1] = l1b;
    endtask

    task automatic t_reset;
        chk("R11 ofs", int'(ofs_o), 0);
        chk("R11 flags", int'({done_o, err_o, measure_o, fifo_rst_o, dummy_rd_o}), 0);
    endtask

    task automatic t_basic;
        win(5, 14, 9, 20);
        run_cal(10, 12, 1'b1, 1'b0, 12);
        chk("R9 done", int'(done_o), 1);
        chk("R9 lane0 centre", lane_ofs(0), 9);
        chk("R10 lane1 centre", lane_ofs(1), 14);
        chk("R6 lane0 lowest probe", amin[0], 4);
        chk("R6 lane1 lowest probe", amin[1], 8);
        chk("R7 lane0 highest probe", amax[0], 15);
        chk("R7 lane1 highest probe", amax[1], 21);
        chk("R1 8-beat done", int'(err_o), 0);
    endtask

    task automatic t_burst4;
        junk_hi = 1'b1;
        win(3, 9, 2, 7);
        run_cal(6, 4, 1'b0, 1'b0, 12);
        chk("R1 4-beat ignores upper beats", int'(done_o), 1);
        chk("R1 lane0 centre", lane_ofs(0), 6);
        chk("R1 lane1 centre", lane_ofs(1), 4);
        run_cal(6, 4, 1'b1, 1'b0, 12);
        chk("R1 8-beat sees upper beats", int'(err_o), 1);
        junk_hi = 1'b0;
    endtask

    task automatic t_wait;
        win(4, 12, 6, 18);
        run_cal(8, 10, 1'b1, 1'b0, 24);
        chk("R5 short wait misses late data", int'(err_o), 1);
        run_cal(8, 10, 1'b1, 1'b1, 24);
        chk("R5 long wait done", int'(done_o), 1);
        chk("R5 lane0 centre", lane_ofs(0), 8);
        chk("R5 lane1 centre", lane_ofs(1), 12);
    endtask

    task automatic t_saturate;
        win(0, 12, 20, 31);
        run_cal(2, 29, 1'b1, 1'b0, 12);
        chk("R8 done", int'(done_o), 1);
        chk("R8 lane0 floor limit", amin[0], 0);
        chk("R8 lane1 ceiling limit", amax[1], 31);
        chk("R8 lane0 centre", lane_ofs(0), 6);
        chk("R8 lane1 centre", lane_ofs(1), 25);
    endtask

    task automatic t_init_max;
        win(0, 4, 25, 31);
        run_cal(0, 31, 1'b1, 1'b0, 12);
        chk("R7 start at max done", int'(done_o), 1);
        chk("R7 lane1 centre", lane_ofs(1), 28);
        chk("R8 lane0 centre", lane_ofs(0), 2);
    endtask

    task automatic t_error;
        win(4, 10, 4, 10);
        run_cal(7, 15, 1'b1, 1'b0, 12);
        @(negedge clk);
        chk("R2 err", int'(err_o), 1);
        chk("R2 no done", int'(done_o), 0);
        chk("R2 lane0 kept", lane_ofs(0), 7);
        chk("R2 lane1 kept", lane_ofs(1), 15);
        repeat (40) @(negedge clk);
        chk("R2 single read", reads, 1);
        run_cal(7, 6, 1'b1, 1'b0, 12);
        chk("R2 err cleared on restart", int'(err_o), 0);
        chk("R2 lane1 centre after restart", lane_ofs(1), 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_basic;
        t_burst4;
        t_wait;
        t_saturate;
        t_init_max;
        t_error;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule